// File: doc/BRIEF.md
# Reduced Bitstream LUT Chain Loader

This block fills the truth tables of a chain of k-input lookup tables from a shortened configuration stream. Each LUT except the last arrives with a few of its table bits missing. Those bits are not stored or sent. The loader rebuilds them while the stream loads, from the order of the next LUT's input-select values. Every LUT still owns all 2^k storage cells, and the rebuilt bits are written into those cells.

A producer chooses each successor's input wiring so that the rank of its input permutation equals the bits being dropped. It then reorders that successor's table to match the chosen wiring. The loader takes the stream one bit per valid/ready beat. On the first beat of each LUT it also samples that LUT's input-select word. Because a LUT's missing bits depend on its successor, each table is held until the successor's first beat arrives, and only then written out.

A single shared rank circuit serves the whole chain. The number of rebuilt bits per LUT is PB = floor(log2(K!)), which is 4 for the default K = 4.

Top module: `lutchain_loader`

## Requirements
- R1: A synchronous active-high `rst` clears the loader: it returns to LUT index 0 and drops any partial table. On the first cycle after reset `in_ready` is 1 and `wr_en` is 0. A chain loaded after a reset that came in the middle of a load is written correctly from LUT 0.
- R2: Stream bits of a LUT fill its table starting at index 0 and rising. A non-last LUT takes 2^K - PB bits (12 for K=4), and the last LUT takes all 2^K bits (16).
- R3: For every LUT n except the last, table indices 2^K-PB up to 2^K-1 hold the rebuilt bits: the low PB bits of the rank of LUT n+1's select word. The rank's most significant of those bits sits at index 2^K-1.
- R4: The select word holds K fields of SEL_W bits, with field i at bits [i*SEL_W +: SEL_W]. For each i, c_i is the number of fields j > i with a value smaller than field i. The rank is the sum of c_i * (K-1-i)!.
- R5: `in_sel` is sampled only on the first accepted bit of each LUT. Its value on every other beat has no effect on any written table or select word.
- R6: Writes come in increasing LUT index order, at most one per cycle, and `wr_sel` carries that LUT's own select word. A non-last LUT n is written one cycle after the first bit of LUT n+1 is accepted. The last LUT is written one cycle after its final bit is accepted.
- R7: From the cycle of the last write until the next reset, `in_ready` stays 0, and any beats offered in that time produce no write.
- R8: A cycle with `in_valid` low neither advances the load nor produces a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream bit offered |
| in_ready | output | 1 | Loader can take a bit; 0 once the chain is complete |
| in_bit | input | 1 | Stream bit |
| in_sel | input | K*SEL_W | Input-select word, sampled on a LUT's first bit |
| wr_en | output | 1 | Table write strobe |
| wr_idx | output | IDX_W | LUT index being written |
| wr_sel | output | K*SEL_W | Select word of the LUT being written |
| wr_table | output | 2^K | Full truth table of the LUT being written |

## Verification
The hardest case to reach is a rank near the top of the usable range coming from a successor whose select values are scattered. In that case the rebuilt bits differ from the stream bits in every position, while junk on `in_sel` during the other beats would go unnoticed by a loose design. The stimulus draws distinct random field values and keeps only permutations whose rank fits in PB bits. It pins one successor at the largest usable rank and another at rank zero. It also drives random values on `in_sel` for all non-first beats. Random stall gaps, a reset in the middle of a table, and beats offered after completion complete the set of cases.

// File: rtl/lutchain_pkg.sv
package lutchain_pkg;

    // n! for small n, used for permutation weights
    function automatic int fact(input int n);
        int r;
        r = 1;
        for (int i = 2; i <= n; i++) r = r * i;
        return r;
    endfunction

    // floor(log2(v)) for v >= 1
    function automatic int flog2(input int v);
        int r;
        r = 0;
        while ((v >> (r + 1)) > 0) r++;
        return r;
    endfunction

endpackage

// File: rtl/lutchain_perm_rank.sv
module lutchain_perm_rank
    import lutchain_pkg::*;
#(
    parameter int K     = 4,
    parameter int SEL_W = 4,
    parameter int PB    = 4
) (
    input  logic [K*SEL_W-1:0] sel,
    output logic [PB-1:0]      regen_bits
);
    localparam int CW = $clog2(K) + 1;

    logic [PB-1:0] term [K];

    genvar i;
    generate
        for (i = 0; i < K; i++) begin : g_pos
            localparam int WEIGHT = fact(K - 1 - i);
            logic [CW-1:0] smaller;
            always_comb begin
                smaller = '0;
                for (int j = i + 1; j < K; j++) begin
                    if (sel[j*SEL_W +: SEL_W] < sel[i*SEL_W +: SEL_W])
                        smaller = smaller + CW'(1);
                end
            end
            assign term[i] = PB'(32'(smaller) * WEIGHT);
        end
    endgenerate

    always_comb begin
        regen_bits = '0;
        for (int n = 0; n < K; n++) regen_bits = regen_bits + term[n];
    end

endmodule

// File: rtl/lutchain_tbl_merge.sv
module lutchain_tbl_merge #(
    parameter int TBL = 16,
    parameter int PB  = 4
) (
    input  logic [TBL-1:0] partial,
    input  logic [PB-1:0]  regen,
    input  logic           keep_all,
    output logic [TBL-1:0] full
);
    always_comb begin
        if (keep_all) full = partial;
        else          full = {regen, partial[TBL-PB-1:0]};
    end
endmodule

// File: rtl/lutchain_loader.sv
module lutchain_loader
    import lutchain_pkg::*;
#(
    parameter int K        = 4,
    parameter int SEL_W    = 4,
    parameter int NUM_LUTS = 5,
    parameter int IDX_W    = ($clog2(NUM_LUTS) > 0) ? $clog2(NUM_LUTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic                  in_bit,
    input  logic [K*SEL_W-1:0]    in_sel,
    output logic                  wr_en,
    output logic [IDX_W-1:0]      wr_idx,
    output logic [K*SEL_W-1:0]    wr_sel,
    output logic [(1<<K)-1:0]     wr_table
);
    localparam int TBL    = 1 << K;
    localparam int PB     = flog2(fact(K));
    localparam int SW_ALL = K * SEL_W;
    localparam int DATA_N = TBL - PB;
    localparam int CNT_W  = $clog2(TBL + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LUTS - 1);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  cnt;
        logic [TBL-1:0]    tbl;
        logic [SW_ALL-1:0] sel;
        logic              pending;
        logic              done;
        logic              wr_en;
        logic [IDX_W-1:0]  wr_idx;
        logic [SW_ALL-1:0] wr_sel;
        logic [TBL-1:0]    wr_table;
    } state_t;

    state_t q, d;

    logic              accept;
    logic              is_last;
    logic [CNT_W-1:0]  need_n;
    logic [TBL-1:0]    tbl_wb;
    logic [PB-1:0]     regen_bits;
    logic [TBL-1:0]    merge_src;
    logic [TBL-1:0]    merged;

    assign accept  = in_valid && !q.done;
    assign is_last = (q.idx == LAST);
    assign need_n  = is_last ? CNT_W'(TBL) : CNT_W'(DATA_N);

    always_comb begin
        tbl_wb = q.tbl;
        tbl_wb[q.cnt[K-1:0]] = in_bit;
    end

    // shared regenerator: rank of the arriving LUT's wiring
    lutchain_perm_rank #(.K(K), .SEL_W(SEL_W), .PB(PB)) u_rank (
        .sel        (in_sel),
        .regen_bits (regen_bits)
    );

    assign merge_src = q.pending ? q.tbl : tbl_wb;

    lutchain_tbl_merge #(.TBL(TBL), .PB(PB)) u_merge (
        .partial  (merge_src),
        .regen    (regen_bits),
        .keep_all (!q.pending),
        .full     (merged)
    );

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (accept) begin
            if (q.pending) begin
                // first bit of successor: commit the held table
                d.wr_en    = 1'b1;
                d.wr_idx   = q.idx;
                d.wr_sel   = q.sel;
                d.wr_table = merged;
                d.idx      = q.idx + IDX_W'(1);
                d.tbl      = '0;
                d.tbl[0]   = in_bit;
                d.cnt      = CNT_W'(1);
                d.sel      = in_sel;
                d.pending  = 1'b0;
            end else begin
                if (q.cnt == '0) d.sel = in_sel;
                d.tbl = tbl_wb;
                d.cnt = q.cnt + CNT_W'(1);
                if (q.cnt + CNT_W'(1) == need_n) begin
                    if (is_last) begin
                        d.wr_en    = 1'b1;
                        d.wr_idx   = q.idx;
                        d.wr_sel   = (q.cnt == '0) ? in_sel : q.sel;
                        d.wr_table = merged;
                        d.done     = 1'b1;
                    end else begin
                        d.pending  = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign in_ready = !q.done;
    assign wr_en    = q.wr_en;
    assign wr_idx   = q.wr_idx;
    assign wr_sel   = q.wr_sel;
    assign wr_table = q.wr_table;

endmodule

// File: rtl/lutchain_loader_chk.sv
module lutchain_loader_chk #(
    parameter int NUM_LUTS = 5,
    parameter int IDX_W    = 3,
    parameter int TBL      = 16,
    parameter int PB       = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [TBL-1:0]   wr_table,
    input logic [PB-1:0]    regen_bits
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LUTS - 1);

    logic [IDX_W-1:0] exp_idx;
    always_ff @(posedge clk) begin
        if (rst)        exp_idx <= '0;
        else if (wr_en) exp_idx <= exp_idx + IDX_W'(1);
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!wr_en && in_ready));

    a_r3_regen_top: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != LAST) |-> (wr_table[TBL-1 -: PB] == $past(regen_bits)));

    a_r6_order: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx == exp_idx));

    a_r6_after_accept: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(in_valid && in_ready));

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> !in_ready);

    a_r7_last_write: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) |-> (wr_en && wr_idx == LAST));

endmodule

bind lutchain_loader lutchain_loader_chk #(
    .NUM_LUTS (NUM_LUTS),
    .IDX_W    (IDX_W),
    .TBL      (TBL),
    .PB       (PB)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_table   (wr_table),
    .regen_bits (regen_bits)
);

// File: tb/lutchain_loader_tb.sv
module lutchain_loader_tb;
    localparam int K     = 4;
    localparam int SW    = 4;
    localparam int NL    = 5;
    localparam int IW    = 3;
    localparam int TBL   = 16;
    localparam int PB    = 4;
    localparam int DN    = TBL - PB;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_ready;
    logic          in_bit;
    logic [15:0]   in_sel;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [15:0]   wr_sel;
    logic [15:0]   wr_table;

    int checks = 0;
    int fails  = 0;

    logic [15:0] tbls [NL];
    logic [15:0] sels [NL];

    always #5 clk = ~clk;

    lutchain_loader #(.K(K), .SEL_W(SW), .NUM_LUTS(NL)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_bit(in_bit), .in_sel(in_sel), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_sel(wr_sel), .wr_table(wr_table)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R4 rank, written from the requirement
    function automatic int rank_of(input logic [15:0] s);
        int w [4] = '{6, 2, 1, 1};
        int r = 0;
        for (int i = 0; i < K; i++) begin
            int c = 0;
            for (int j = i + 1; j < K; j++)
                if (s[j*SW +: SW] < s[i*SW +: SW]) c++;
            r += c * w[i];
        end
        return r;
    endfunction

    function automatic logic [15:0] make_sel();
        logic [15:0] s;
        do begin
            for (int i = 0; i < K; i++) begin
                bit dup;
                do begin
                    s[i*SW +: SW] = 4'($urandom_range(0, 15));
                    dup = 1'b0;
                    for (int j = 0; j < i; j++)
                        if (s[j*SW +: SW] == s[i*SW +: SW]) dup = 1'b1;
                end while (dup);
            end
        end while (rank_of(s) >= (1 << PB));
        return s;
    endfunction

    task automatic idle_cycle(input string req);
        in_valid = 1'b0;
        in_sel   = 16'($urandom);
        @(posedge clk); @(negedge clk);
        check(wr_en == 1'b0, req, "write during idle", 32'(wr_en), 0);
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 1);
        check(wr_en == 1'b0, "R1", "wr_en after reset", 32'(wr_en), 0);
    endtask

    // one accepted beat, then the write expected at the next edge
    task automatic send_beat(input logic b, input logic [15:0] s,
                             input bit exp_wr, input int exp_n);
        in_valid = 1'b1; in_bit = b; in_sel = s;
        check(in_ready == 1'b1, "R8", "in_ready while loading", 32'(in_ready), 1);
        @(posedge clk); @(negedge clk);
        check(wr_en == exp_wr, "R6", "write strobe timing", 32'(wr_en), 32'(exp_wr));
        if (exp_wr && wr_en) begin
            check(wr_idx == IW'(exp_n), "R6", "write index", 32'(wr_idx), 32'(exp_n));
            check(wr_sel == sels[exp_n], "R5", "written select word",
                  32'(wr_sel), 32'(sels[exp_n]));
            check(wr_table == tbls[exp_n],
                  (exp_n == NL - 1) ? "R2" : "R3", "written table",
                  32'(wr_table), 32'(tbls[exp_n]));
        end
    endtask

    task automatic run_chain(input int gap_pct, input bit directed);
        for (int n = 0; n < NL; n++) sels[n] = make_sel();
        if (directed) begin
            sels[1] = 16'h0312;   // rank 15, largest usable
            sels[2] = 16'h3210;   // rank 0
            check(rank_of(sels[1]) == 15, "R4", "bench rank of 0312", 32'(rank_of(sels[1])), 15);
        end
        for (int n = 0; n < NL; n++) begin
            tbls[n] = 16'($urandom);
            if (n != NL - 1)
                tbls[n][TBL-1 -: PB] = PB'(rank_of(sels[n + 1]));
        end
        for (int n = 0; n < NL; n++) begin
            int nb = (n == NL - 1) ? TBL : DN;
            for (int b = 0; b < nb; b++) begin
                bit ew;
                int en;
                while ($urandom_range(0, 99) < gap_pct) idle_cycle("R8");
                ew = 1'b0; en = 0;
                if (b == 0 && n > 0)            begin ew = 1'b1; en = n - 1; end
                if (n == NL - 1 && b == nb - 1) begin ew = 1'b1; en = n;     end
                send_beat(tbls[n][b], (b == 0) ? sels[n] : 16'($urandom), ew, en);
            end
        end
        check(in_ready == 1'b0, "R7", "in_ready after last LUT", 32'(in_ready), 0);
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1; in_bit = 1'($urandom); in_sel = 16'($urandom);
            @(posedge clk); @(negedge clk);
            check(wr_en == 1'b0, "R7", "write after completion", 32'(wr_en), 0);
            check(in_ready == 1'b0, "R7", "in_ready stays low", 32'(in_ready), 0);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20110));
        rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0; in_sel = '0;
        @(negedge clk);
        do_reset();
        // R1: partial load interrupted by reset
        for (int b = 0; b < 7; b++) begin
            in_valid = 1'b1; in_bit = 1'($urandom); in_sel = 16'($urandom);
            @(posedge clk); @(negedge clk);
        end
        do_reset();
        run_chain(0, 1'b1);
        for (int c = 0; c < 6; c++) begin
            do_reset();
            run_chain((c % 2 == 0) ? 40 : 0, 1'b0);
        end
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule